// File: doc/BRIEF.md
# Exception Vector Catch Matcher

This block watches the instruction fetch stream of a 32-bit processor running in its legacy execution mode and asks the debug logic to halt the core when a fetch reaches an exception vector that debug software has chosen to trap. The fetch address is compared against a vector table base. The word slot inside the 32-byte table is decoded to an exception type. The enable bit for that type is then taken from a 32-bit catch-control word.

The control word holds two groups of enable bits, one for the secure state and one for the non-secure state. The fetch's security flag picks the group. When the core has no top privilege level, a configuration input collapses the layout: only the low group counts, whatever the security state. The result is registered. A hit shows as a single-cycle pulse one clock after the fetch, together with a 3-bit code that names the caught exception.

Top module: `vector_catch`

## Requirements
- R1: A synchronous active-high reset clears `catch_pulse` to 0 and `catch_kind` to 0 on the next clock edge, whatever the other inputs are.
- R2: A qualifying fetch raises `catch_pulse` in the cycle after the fetch, for exactly one cycle per fetch. Back-to-back qualifying fetches give a pulse in each cycle. `catch_kind` encodes the slot as follows: 1 = undefined instruction (offset 0x04), 2 = supervisor call (0x08), 3 = prefetch abort (0x0C), 4 = data abort (0x10), 6 = IRQ (0x18), 7 = FIQ (0x1C). The code is always the offset divided by 4.
- R3: When `top_level_present`=1 and `nonsecure`=0, the enable for the exception with code k is control bit k, for k in {1,2,3,4,6,7}.
- R4: When `top_level_present`=1 and `nonsecure`=1, the enable for the exception with code k is control bit 24+k, that is bits 25, 26, 27, 28, 30 and 31.
- R5: When `top_level_present`=0, the enable for code k is control bit k in both security states, and control bits 31:8 have no effect.
- R6: Control bits 0, 5, 8 to 24 and 29 never cause a catch. Fetches at offsets 0x00 and 0x14 are never caught.
- R7: No catch is raised in the cycle after a cycle with `fetch_valid`=0.
- R8: A catch needs all of the following: `vec_base[4:0]`=0, `fetch_addr[31:5]` equal to `vec_base[31:5]`, and `fetch_addr[1:0]`=0. If any of these fails, there is no catch.
- R9: `catch_kind` is 0 in every cycle in which `catch_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch address is valid this cycle |
| fetch_addr | input | 32 | Instruction fetch byte address |
| vec_base | input | 32 | Base of the exception vector table |
| nonsecure | input | 1 | 1 = fetch in non-secure state |
| top_level_present | input | 1 | 1 = top privilege level implemented (split enable layout) |
| catch_ctrl | input | 32 | Catch-enable control word |
| catch_pulse | output | 1 | One-cycle catch request |
| catch_kind | output | 3 | Caught exception code, 0 when idle |

## Verification
On every cycle, the in-RTL assertions check the following: the code is zero when no pulse is present, a pulse always follows a valid fetch on an aligned base, a pulse never carries the code of a reserved slot, and the enable bit of the selected group was set in the previous cycle. Only the bench scenarios can show that a catch actually happens when it should. The directed sweeps cover all slots in every layout mode, back-to-back pulses, reserved bits that are set and misaligned addresses. Seeded random fetches around the table are compared against an independent model.

// File: rtl/vc_pkg.sv
package vc_pkg;

    localparam int ADDR_W    = 32;
    localparam int CTRL_W    = 32;
    localparam int SLOT_BITS = 3;
    localparam int SLOTS     = 1 << SLOT_BITS;
    localparam int ALIGN_BITS = SLOT_BITS + 2;
    localparam int NS_LSB    = 24;

    typedef enum logic [SLOT_BITS-1:0] {
        EXC_NONE  = 3'd0,
        EXC_UNDEF = 3'd1,
        EXC_SVC   = 3'd2,
        EXC_PABT  = 3'd3,
        EXC_DABT  = 3'd4,
        EXC_RSVD  = 3'd5,
        EXC_IRQ   = 3'd6,
        EXC_FIQ   = 3'd7
    } exc_kind_e;

    typedef struct packed {
        logic      hit;
        exc_kind_e kind;
    } slot_match_t;

    // Slots 0 (reset) and 5 (unused) can never be caught.
    function automatic logic slot_catchable(input int s);
        return !(s == 0 || s == 5);
    endfunction

endpackage

// File: rtl/vc_window_match.sv
module vc_window_match
    import vc_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int ALIGN = ALIGN_BITS
) (
    input  logic          fetch_valid,
    input  logic [AW-1:0] fetch_addr,
    input  logic [AW-1:0] vec_base,
    output slot_match_t   match
);
    localparam int SB = ALIGN - 2;

    logic base_aligned;
    logic same_window;
    logic word_aligned;

    always_comb begin
        base_aligned = (vec_base[ALIGN-1:0] == '0);
        same_window  = (fetch_addr[AW-1:ALIGN] == vec_base[AW-1:ALIGN]);
        word_aligned = (fetch_addr[1:0] == 2'b00);
        match.hit    = fetch_valid && base_aligned && same_window && word_aligned;
        match.kind   = exc_kind_e'(fetch_addr[ALIGN-1:2]);
    end

    initial begin
        assert (SB == SLOT_BITS) else $error("slot width mismatch");
    end
endmodule

// File: rtl/vc_enable_select.sv
module vc_enable_select
    import vc_pkg::*;
#(
    parameter int CW     = CTRL_W,
    parameter int NSB    = NS_LSB,
    parameter int NSLOTS = SLOTS
) (
    input  logic [CW-1:0]     catch_ctrl,
    input  logic              nonsecure,
    input  logic              top_level_present,
    output logic [NSLOTS-1:0] slot_en
);
    logic use_ns_group;
    assign use_ns_group = top_level_present && nonsecure;

    for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
        if (slot_catchable(s)) begin : g_live
            assign slot_en[s] = use_ns_group ? catch_ctrl[NSB + s] : catch_ctrl[s];
        end else begin : g_dead
            assign slot_en[s] = 1'b0;
        end
    end
endmodule

// File: rtl/vector_catch.sv
module vector_catch
    import vc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 fetch_valid,
    input  logic [ADDR_W-1:0]    fetch_addr,
    input  logic [ADDR_W-1:0]    vec_base,
    input  logic                 nonsecure,
    input  logic                 top_level_present,
    input  logic [CTRL_W-1:0]    catch_ctrl,
    output logic                 catch_pulse,
    output logic [SLOT_BITS-1:0] catch_kind
);
    slot_match_t      match;
    logic [SLOTS-1:0] slot_en;
    slot_match_t      next_q, cur_q;

    vc_window_match #(.AW(ADDR_W), .ALIGN(ALIGN_BITS)) u_window (
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .vec_base    (vec_base),
        .match       (match)
    );

    vc_enable_select #(.CW(CTRL_W), .NSB(NS_LSB), .NSLOTS(SLOTS)) u_enable (
        .catch_ctrl        (catch_ctrl),
        .nonsecure         (nonsecure),
        .top_level_present (top_level_present),
        .slot_en           (slot_en)
    );

    always_comb begin
        next_q.hit  = match.hit && slot_en[match.kind];
        next_q.kind = next_q.hit ? match.kind : EXC_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q.hit  <= 1'b0;
            cur_q.kind <= EXC_NONE;
        end else begin
            cur_q <= next_q;
        end
    end

    assign catch_pulse = cur_q.hit;
    assign catch_kind  = cur_q.kind;

    // R1: reset leaves the output idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) |-> (!catch_pulse && catch_kind == 3'd0));

    // R9: code is zero while no pulse
    assert_kind_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !catch_pulse |-> catch_kind == 3'd0);

    // R7: a pulse needs a valid fetch one cycle earlier
    assert_needs_fetch_R7: assert property (@(posedge clk) disable iff (rst)
        catch_pulse |-> $past(fetch_valid));

    // R6: reserved slots never reported
    assert_no_reserved_R6: assert property (@(posedge clk) disable iff (rst)
        catch_pulse |-> (catch_kind != 3'd0 && catch_kind != 3'd5));

    // R8: base must have been table aligned
    assert_aligned_base_R8: assert property (@(posedge clk) disable iff (rst)
        catch_pulse |-> ($past(vec_base[ALIGN_BITS-1:0]) == '0));

    // R4: non-secure split layout uses the upper group
    assert_ns_group_R4: assert property (@(posedge clk) disable iff (rst)
        (catch_pulse && $past(top_level_present) && $past(nonsecure)) |->
        ((($past(catch_ctrl) >> (NS_LSB + int'(catch_kind))) & 32'd1) != 32'd0));

    // R3 R5: other modes use the low group
    assert_low_group_R3: assert property (@(posedge clk) disable iff (rst)
        (catch_pulse && !($past(top_level_present) && $past(nonsecure))) |->
        ((($past(catch_ctrl) >> int'(catch_kind)) & 32'd1) != 32'd0));
endmodule

// File: tb/test_vector_catch.sv
`timescale 1ns/1ps
module test_vector_catch;
    logic        clk = 1'b0;
    logic        rst;
    logic        fetch_valid;
    logic [31:0] fetch_addr, vec_base, catch_ctrl;
    logic        nonsecure, top_level_present;
    logic        catch_pulse;
    logic [2:0]  catch_kind;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    vector_catch i_vector_catch (
        .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .vec_base(vec_base), .nonsecure(nonsecure),
        .top_level_present(top_level_present), .catch_ctrl(catch_ctrl),
        .catch_pulse(catch_pulse), .catch_kind(catch_kind)
    );

    function automatic logic [3:0] model(input logic v, input logic [31:0] a,
                                         input logic [31:0] b, input logic ns,
                                         input logic top, input logic [31:0] c);
        int slot;
        int bitpos;
        if (!v || b[4:0] != 5'd0 || a[31:5] != b[31:5] || a[1:0] != 2'b00)
            return 4'd0;
        slot = int'(a[4:2]);
        if (slot == 0 || slot == 5) return 4'd0;
        bitpos = (top && ns) ? 24 + slot : slot;
        if (!c[bitpos]) return 4'd0;
        return {1'b1, 3'(slot)};
    endfunction

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got pulse=%0b kind=%0d, expected pulse=%0b kind=%0d",
                     req, act[3], act[2:0], exp[3], exp[2:0]);
        end
    endtask

    task automatic apply(input string req, input logic v, input logic [31:0] a,
                         input logic [31:0] b, input logic ns, input logic top,
                         input logic [31:0] c);
        @(negedge clk);
        fetch_valid = v; fetch_addr = a; vec_base = b;
        nonsecure = ns; top_level_present = top; catch_ctrl = c;
        @(posedge clk); #1;
        chk(req, {catch_pulse, catch_kind}, model(v, a, b, ns, top, c));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: got hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] base;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; fetch_valid = 0; fetch_addr = 0; vec_base = 0;
        nonsecure = 0; top_level_present = 1; catch_ctrl = 32'hFFFF_FFFF;
        @(negedge clk);
        fetch_valid = 1; fetch_addr = 32'h0000_0104; vec_base = 32'h0000_0100;
        @(posedge clk); #1;
        chk("R1 reset", {catch_pulse, catch_kind}, 4'd0);
        @(negedge clk); rst = 1'b0;

        base = 32'h8000_1000;
        // R3 secure split layout, every slot
        for (int s = 0; s < 8; s++)
            apply("R3", 1, base + 32'(s * 4), base, 0, 1, 32'h0000_00DE);
        // R4 non-secure split layout; low bits must not matter
        for (int s = 0; s < 8; s++)
            apply("R4", 1, base + 32'(s * 4), base, 1, 1, 32'hDE00_0000);
        for (int s = 0; s < 8; s++)
            apply("R4", 1, base + 32'(s * 4), base, 1, 1, 32'h0000_00FF);
        // R5 collapsed layout, both states, high bits ignored
        for (int s = 0; s < 8; s++) begin
            apply("R5", 1, base + 32'(s * 4), base, 1, 0, 32'h0000_00DE);
            apply("R5", 1, base + 32'(s * 4), base, 0, 0, 32'hFFFF_FF00);
        end
        // R6 only reserved bits set
        for (int s = 0; s < 8; s++) begin
            apply("R6", 1, base + 32'(s * 4), base, 0, 1, 32'h21FF_FF21);
            apply("R6", 1, base + 32'(s * 4), base, 1, 1, 32'h21FF_FF21);
        end
        apply("R6 offset 0x14", 1, base + 32'h14, base, 0, 0, 32'hFFFF_FFFF);
        apply("R6 offset 0x00", 1, base, base, 1, 1, 32'hFFFF_FFFF);
        // R2 back-to-back pulses then idle
        apply("R2 first", 1, base + 32'h1C, base, 0, 1, 32'hFFFF_FFFF);
        apply("R2 second", 1, base + 32'h04, base, 0, 1, 32'hFFFF_FFFF);
        apply("R2 drop", 0, base + 32'h04, base, 0, 1, 32'hFFFF_FFFF);
        // R7 no valid
        apply("R7", 0, base + 32'h18, base, 1, 1, 32'hFFFF_FFFF);
        // R8 misalignment and window mismatch
        apply("R8 base", 1, base + 32'h0C, base + 32'h04, 0, 1, 32'hFFFF_FFFF);
        apply("R8 byte", 1, base + 32'h0E, base, 0, 1, 32'hFFFF_FFFF);
        apply("R8 window", 1, base + 32'h2C, base, 0, 1, 32'hFFFF_FFFF);
        // R9 idle code, random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] b, a;
            b = $urandom();
            if ($urandom_range(0, 7) != 0) b[4:0] = 5'd0;
            a = b + 32'($urandom_range(0, 31));
            if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
            if ($urandom_range(0, 9) == 0) a = $urandom();
            apply("R9 random", 1'($urandom_range(0, 5) != 0), a, b,
                  1'($urandom()), 1'($urandom()), $urandom());
        end
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule